// File: doc/BRIEF.md
# Bus error event capture unit

This block sits beside a system bus arbiter and its bus monitor and keeps a record of bus failures. Each detected failure arrives as a one-cycle pulse on one line of a six-line event input, where the line index is the event code. In the same cycle the bus presents the attributes of the transaction that is in flight: master identifier, burst flag, transfer size and transfer type. Every pulse sets a sticky event bit. Enabled bits raise a registered interrupt.

The attributes of the first failure are frozen in an attribute word. No later failure overwrites that word until software has cleared every event bit. Only the power-on reset clears the word. The system reset, which stands for soft and hard resets, leaves it intact. Software can therefore read the cause of a failure that deadlocked the bus even after the system has been reset. A small select/write/read-data port gives access to the event bits (write one to clear), the interrupt enables and the read-only attribute word.

Top module: `bus_err_capture`

## Requirements
- R1: Event bits are read at select 0, one bit per event code (bit n = code n). A pulse on line n sets bit n, and the bit stays set until software writes 1 to it at select 0. When a pulse and a clearing write hit the same bit in one cycle, the bit stays set.
- R2: While either reset is high, the event bits, the enable bits and the interrupt output are all forced to zero.
- R3: Interrupt enables are read and written at select 1, bits [5:0], one per event code. A 1 enables the interrupt and a 0 disables it.
- R4: irq is 1 in the cycle after any event bit is set together with its enable bit, and 0 otherwise.
- R5: When a pulse arrives while all event bits are clear, the attribute word captures the attributes presented in the same cycle as that pulse.
- R6: When several pulses arrive in one cycle, the attribute word records the lowest code among them, and every pulsed line still sets its own event bit. Codes: 0 address timeout, 1 data timeout, 2 address-only transfer, 3 external control word transfer, 4 reserved transfer type, 5 transfer error.
- R7: While any event bit is set, the attribute word does not change.
- R8: Only por_rst clears the attribute word. sys_rst leaves it unchanged.
- R9: The attribute word is read at select 2 and writes to it have no effect. Its layout is: event code [2:0], burst [3], size [3+SZ_W:4], transfer type [7+TT_W:8], master ID [15+MID_W:16]. All other bits read 0. The reset value is all zeros.
- R10: reg_rdata shows the register chosen by reg_sel one cycle after reg_sel is applied. Select 3 reads as zero.
- R11: Pulses that arrive while either reset is high are ignored. They set no event bit and capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high, clears everything |
| sys_rst | input | 1 | Soft/hard reset, synchronous, active high, keeps the attribute word |
| ev_pulse | input | 6 | Event pulses, index = event code |
| bus_mid | input | MID_W | Master ID of the current transaction |
| bus_burst | input | 1 | Burst flag of the current transaction |
| bus_size | input | SZ_W | Transfer size of the current transaction |
| bus_type | input | TT_W | Transfer type of the current transaction |
| reg_sel | input | 2 | Register select: 0 events, 1 enables, 2 attributes |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 6 | Write data (clear bits or enable bits) |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | Registered interrupt |

## Verification
Some properties are checked on every cycle: the freeze of the attribute word while an event bit is set, its survival across sys_rst, the stickiness of event bits, the interrupt timing relative to the enabled bits, and the zero reserved bits on attribute reads. Some behaviour only the bench scenarios can show. These are the actual captured values, the priority among simultaneous pulses, and the overwrite by a fresh event once a soft reset has cleared the event bits. They also include ignored writes to the attribute word and a pulse meeting a clear in the same cycle.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int NUM_EV    = 6;
  localparam int CODE_W    = 3;
  localparam int BURST_BIT = 3;
  localparam int SIZE_LSB  = 4;
  localparam int TYPE_LSB  = 8;
  localparam int MID_LSB   = 16;

  typedef enum logic [CODE_W-1:0] {
    EV_ADDR_TMO  = 3'd0,
    EV_DATA_TMO  = 3'd1,
    EV_ADDR_ONLY = 3'd2,
    EV_CTRL_WORD = 3'd3,
    EV_RSVD_TYPE = 3'd4,
    EV_XFER_ERR  = 3'd5
  } ev_code_e;

  typedef enum logic [1:0] {
    SEL_EVENT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_ATTR  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bec_prio_enc.sv
module bec_prio_enc #(
  parameter int N  = 6,
  parameter int CW = 3
) (
  input  logic [N-1:0]  req,
  output logic [CW-1:0] code,
  output logic          any
);
  // Scan from the top so the lowest set index is the last assignment.
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) code = CW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/bec_event_reg.sv
module bec_event_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev_set,
  input  logic         clr_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] ev_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] clr_bits;
  assign clr_bits = clr_wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      ev_q <= (ev_q & ~clr_bits) | ev_set;   // set wins over clear
      if (mask_wr) mask_q <= wbits;
      irq <= |(ev_q & mask_q);
    end
  end
endmodule

// File: rtl/bec_attr_reg.sv
module bec_attr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         por_rst,
  input  logic         cap_en,
  input  logic [W-1:0] cap_word,
  output logic [W-1:0] attr_q
);
  always_ff @(posedge clk) begin
    if (por_rst)     attr_q <= '0;
    else if (cap_en) attr_q <= cap_word;
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int MID_W = 4,
  parameter int SZ_W  = 3,
  parameter int TT_W  = 5,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic [NUM_EV-1:0] ev_pulse,
  input  logic [MID_W-1:0]  bus_mid,
  input  logic              bus_burst,
  input  logic [SZ_W-1:0]   bus_size,
  input  logic [TT_W-1:0]   bus_type,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [NUM_EV-1:0] reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int N = NUM_EV;

  logic              any_rst;
  logic [N-1:0]      pulse_ok;
  logic [N-1:0]      ev_q;
  logic [N-1:0]      mask_q;
  logic [CODE_W-1:0] first_code;
  logic              any_pulse;
  logic              cap_en;
  logic [DW-1:0]     cap_word;
  logic [DW-1:0]     attr_q;

  assign any_rst  = por_rst | sys_rst;
  assign pulse_ok = any_rst ? '0 : ev_pulse;

  bec_prio_enc #(.N(N), .CW(CODE_W)) u_prio (
    .req  (pulse_ok),
    .code (first_code),
    .any  (any_pulse)
  );

  bec_event_reg #(.N(N)) u_events (
    .clk     (clk),
    .rst     (any_rst),
    .ev_set  (pulse_ok),
    .clr_wr  (reg_wr && reg_sel == SEL_EVENT),
    .mask_wr (reg_wr && reg_sel == SEL_MASK),
    .wbits   (reg_wdata),
    .ev_q    (ev_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  always_comb begin
    cap_word = '0;
    cap_word[CODE_W-1:0]              = first_code;
    cap_word[BURST_BIT]               = bus_burst;
    cap_word[SIZE_LSB +: SZ_W]        = bus_size;
    cap_word[TYPE_LSB +: TT_W]        = bus_type;
    cap_word[MID_LSB +: MID_W]        = bus_mid;
  end

  assign cap_en = any_pulse && (ev_q == '0);

  bec_attr_reg #(.W(DW)) u_attr (
    .clk      (clk),
    .por_rst  (por_rst),
    .cap_en   (cap_en),
    .cap_word (cap_word),
    .attr_q   (attr_q)
  );

  always_ff @(posedge clk) begin
    if (any_rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_sel)
        SEL_EVENT: reg_rdata <= DW'(ev_q);
        SEL_MASK:  reg_rdata <= DW'(mask_q);
        SEL_ATTR:  reg_rdata <= attr_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bec_checker.sv
module bec_checker
  import bec_pkg::*;
#(
  parameter int MID_W = 4,
  parameter int SZ_W  = 3,
  parameter int TT_W  = 5,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              por_rst,
  input logic              sys_rst,
  input logic [NUM_EV-1:0] ev_pulse,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [DW-1:0]     reg_rdata,
  input logic              irq,
  input logic [NUM_EV-1:0] ev_q,
  input logic [NUM_EV-1:0] mask_q,
  input logic [DW-1:0]     attr_q
);
  localparam logic [DW-1:0] USED =
      DW'(32'hF)
    | (DW'((1 << SZ_W) - 1) << SIZE_LSB)
    | (DW'((1 << TT_W) - 1) << TYPE_LSB)
    | (DW'((1 << MID_W) - 1) << MID_LSB);

  assert_sticky_R1: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (ev_q != '0 && !(reg_wr && reg_sel == 2'd0)) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  assert_sys_clears_R2: assert property (@(posedge clk) disable iff (por_rst)
    sys_rst |=> (ev_q == '0 && mask_q == '0 && !irq));

  assert_irq_on_R4: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    ((ev_q & mask_q) != '0) |=> irq);

  assert_irq_off_R4: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    ((ev_q & mask_q) == '0) |=> !irq);

  assert_addr_tmo_first_R6: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (ev_q == '0 && ev_pulse[0]) |=> (attr_q[2:0] == 3'd0));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (por_rst)
    (ev_q != '0) |=> $stable(attr_q));

  assert_keeps_on_sys_R8: assert property (@(posedge clk) disable iff (por_rst)
    sys_rst |=> $stable(attr_q));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (reg_sel == 2'd2) |=> ((reg_rdata & ~USED) == '0));
endmodule

bind bus_err_capture bec_checker #(
  .MID_W(MID_W), .SZ_W(SZ_W), .TT_W(TT_W), .DW(DW)
) u_bec_checker (
  .clk       (clk),
  .por_rst   (por_rst),
  .sys_rst   (sys_rst),
  .ev_pulse  (ev_pulse),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .ev_q      (ev_q),
  .mask_q    (mask_q),
  .attr_q    (attr_q)
);

// File: tb/bus_err_capture_bench.sv
module bus_err_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MID_W = 4, SZ_W = 3, TT_W = 5, DW = 32;

  logic clk = 1'b0;
  logic por_rst = 1'b1, sys_rst = 1'b1;
  logic [5:0] ev_pulse = '0;
  logic [MID_W-1:0] bus_mid = '0;
  logic bus_burst = 1'b0;
  logic [SZ_W-1:0] bus_size = '0;
  logic [TT_W-1:0] bus_type = '0;
  logic [1:0] reg_sel = 2'd3;
  logic reg_wr = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  int errors = 0, checks = 0, cycles = 0;
  bit cmp_en = 0;

  // behavioural reference state
  int unsigned m_ev = 0, m_mask = 0, m_attr = 0, m_rdata = 0;
  bit m_irq = 0;

  bus_err_capture #(.MID_W(MID_W), .SZ_W(SZ_W), .TT_W(TT_W), .DW(DW)) u_bus_err_capture (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .ev_pulse(ev_pulse),
    .bus_mid(bus_mid), .bus_burst(bus_burst), .bus_size(bus_size), .bus_type(bus_type),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: all nexts from values before the edge
  always @(posedge clk) begin
    int unsigned n_ev, n_mask, n_attr, n_rd, pulses, code;
    bit n_irq;
    pulses = (por_rst || sys_rst) ? 0 : int'(ev_pulse);
    n_attr = m_attr;
    if (por_rst) n_attr = 0;
    else if (pulses != 0 && m_ev == 0) begin
      code = 0;
      while (((pulses >> code) & 1) == 0) code++;
      n_attr = code + (int'(bus_burst) * 8) + (int'(bus_size) * 16)
             + (int'(bus_type) * 256) + (int'(bus_mid) * 65536);
    end
    if (por_rst || sys_rst) begin
      n_ev = 0; n_mask = 0; n_irq = 0; n_rd = 0;
    end else begin
      n_ev = m_ev;
      if (reg_wr && reg_sel == 2'd0) n_ev = n_ev & ~int'(reg_wdata);
      n_ev = n_ev | pulses;
      n_mask = (reg_wr && reg_sel == 2'd1) ? int'(reg_wdata) : m_mask;
      n_irq = (m_ev & m_mask) != 0;
      case (reg_sel)
        2'd0: n_rd = m_ev;
        2'd1: n_rd = m_mask;
        2'd2: n_rd = m_attr;
        default: n_rd = 0;
      endcase
    end
    m_ev = n_ev; m_mask = n_mask; m_attr = n_attr; m_irq = n_irq; m_rdata = n_rd;
  end

  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      check("R10 model rdata", reg_rdata, m_rdata);
      check("R4 model irq", {31'd0, irq}, {31'd0, m_irq});
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; reg_wr = 0;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [5:0] d);
    @(negedge clk); reg_sel = s; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(input logic [5:0] p, input logic [3:0] mid, input logic b,
                       input logic [2:0] sz, input logic [4:0] ty);
    @(negedge clk); ev_pulse = p; bus_mid = mid; bus_burst = b; bus_size = sz; bus_type = ty;
    @(negedge clk); ev_pulse = '0; bus_mid = '0; bus_burst = 0; bus_size = '0; bus_type = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    cmp_en = 1;
    por_rst = 0; sys_rst = 0;
    rd(2'd0, v); check("R2 events after reset", v, 32'h0);
    rd(2'd1, v); check("R2 enables after reset", v, 32'h0);
    rd(2'd2, v); check("R9 attribute reset zero", v, 32'h0);
    check("R2 irq after reset", {31'd0, irq}, 32'h0);

    wr(2'd1, 6'h02);
    rd(2'd1, v); check("R3 enable readback", v, 32'h02);

    pulse(6'h02, 4'h5, 1'b1, 3'd2, 5'h11);
    rd(2'd2, v); check("R5 first capture", v, 32'h0005_1129);
    rd(2'd0, v); check("R1 event bit set", v, 32'h02);
    check("R4 irq raised", {31'd0, irq}, 32'h1);

    pulse(6'h20, 4'h9, 1'b0, 3'd5, 5'h03);
    rd(2'd2, v); check("R7 no overwrite while set", v, 32'h0005_1129);
    rd(2'd0, v); check("R1 second bit sticky", v, 32'h22);

    wr(2'd2, 6'h3F);
    rd(2'd2, v); check("R9 write ignored", v, 32'h0005_1129);

    wr(2'd0, 6'h22);
    rd(2'd0, v); check("R1 write one clears", v, 32'h0);
    check("R4 irq dropped", {31'd0, irq}, 32'h0);

    pulse(6'h2C, 4'hA, 1'b0, 3'd7, 5'h1F);
    rd(2'd2, v); check("R6 lowest code wins", v, 32'h000A_1F72);
    rd(2'd0, v); check("R6 all bits set", v, 32'h2C);

    @(negedge clk); sys_rst = 1; ev_pulse = 6'h01;
    @(negedge clk);
    @(negedge clk); sys_rst = 0; ev_pulse = '0;
    rd(2'd0, v); check("R11 pulses ignored in reset", v, 32'h0);
    rd(2'd1, v); check("R2 enables cleared by soft reset", v, 32'h0);
    rd(2'd2, v); check("R8 attribute kept across soft reset", v, 32'h000A_1F72);

    pulse(6'h01, 4'h3, 1'b1, 3'd1, 5'h02);
    rd(2'd2, v); check("R5 overwrite after soft reset", v, 32'h0003_0218);

    @(negedge clk); reg_sel = 2'd0; reg_wr = 1; reg_wdata = 6'h10; ev_pulse = 6'h10;
    @(negedge clk); reg_wr = 0; ev_pulse = '0;
    rd(2'd0, v); check("R1 set wins over clear", v, 32'h11);
    rd(2'd2, v); check("R7 frozen again", v, 32'h0003_0218);
    rd(2'd3, v); check("R10 select 3 reads zero", v, 32'h0);

    @(negedge clk); por_rst = 1;
    @(negedge clk); por_rst = 0;
    rd(2'd2, v); check("R8 power-on clears attribute", v, 32'h0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule